// File: doc/BRIEF.md
# Interline CCD Readout Timing Generator

This block derives every digital timing signal an interline-transfer CCD sensor needs from one pixel clock. Each pixel period is four clocks long. Inside that period the block produces the reset-gate pulse, the two complementary horizontal transfer phases and the two correlated-double-sampling strobes in a fixed order. A pixel counter and a line counter step across the whole array. That array includes a horizontal blanking interval, dummy positions, optical-black columns and lines, and the effective area.

In the blanking interval at the start of each line, the horizontal phases rest at their idle levels. The four vertical phases then step through a short transfer sequence. On the first line of a frame, a sensor-gate pulse can be laid onto both halves of the split second vertical phase. It appears as a separate high-level enable per half. A substrate sweep pulse clears the photodiodes once per line on the lines before a programmed shutter line. Flag outputs tell downstream logic where the data is valid, where it is optical black, where the clamp should run, and whether a pixel lies in the effective or the recorded window.

The shutter line and the sensor-gate enable are captured while reset is held and at every frame start. A change made in the middle of a frame therefore waits for the next frame. Every output is registered and describes the array position that the counters hold in the same cycle.

Top module: `ccd_tg`

## Requirements
- R1: The position counts through four clocks per pixel, H_TOTAL = H_BLANK+H_DUMMY+H_OBF+H_EFF+H_OBR pixels per line, and V_TOTAL = V_DUMMY+V_OBF+V_EFF+V_OBR lines per frame, then wraps to pixel 0 of line 0. Pixel 0 is the first blanking pixel. Line 0 is the first dummy line.
- R2: Outside blanking, within a pixel (clock slots 0 to 3): `rg` is high in slot 0, `shp` is high in slot 1, `h1` is high and `h2` low in slots 2 and 3, `h1` is low and `h2` high in slots 0 and 1, and `shd` is high in slot 3.
- R3: During the blanking pixels (pixel < H_BLANK): `h1`=0, `h2`=1, `rg`=0, `shp`=0, `shd`=0 and `pblk`=1. `pblk` is 0 elsewhere.
- R4: On every line, blanking pixel 0 drives `v1`, pixels 1 and 3 drive `v2a` and `v2b`, and pixel 2 drives `v3`. Each lasts a whole pixel. All vertical phases are low at other times, except as R5 adds.
- R5: When the captured gate enable is 1, line 0 blanking pixel 4 drives `sg_a`, `sg_b`, `v2a` and `v2b` high. `sg_a` and `sg_b` are low at all other times.
- R6: `sub` is high for blanking pixel H_BLANK-1 on each line whose index is less than the captured shutter line, and never outside blanking.
- R7: `pix_valid` is high outside blanking, outside the H_DUMMY dummy pixels and outside the V_DUMMY dummy lines. `ob` is high when `pix_valid` is high and either the pixel is in the H_OBF front or H_OBR rear black columns, or the line is in the V_OBF front or V_OBR rear black lines.
- R8: `eff_win` is high inside the H_EFF × V_EFF effective area. `rec_win` is high inside the H_REC × V_REC area centred in it (margins (H_EFF-H_REC)/2 and (V_EFF-V_REC)/2).
- R9: `clamp` is high for the H_OBR rear black pixels of every line.
- R10: While `rst` is high at a clock edge, the counters return to zero and all outputs go idle (`h2`=1, every other output 0).
- R11: `shut_line` and `sg_en` are captured during reset and when the position wraps to the frame start. A change at any other time takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| shut_line | input | VW+1 | lines below this index receive the sweep pulse |
| sg_en | input | 1 | sensor-gate request for the next frame |
| h1 | output | 1 | horizontal phase 1 |
| h2 | output | 1 | horizontal phase 2 |
| rg | output | 1 | reset-gate pulse |
| shp | output | 1 | reset-level sample strobe |
| shd | output | 1 | data-level sample strobe |
| v1 | output | 1 | vertical phase 1 |
| v2a | output | 1 | vertical phase 2, half A |
| v2b | output | 1 | vertical phase 2, half B |
| v3 | output | 1 | vertical phase 3 |
| sg_a | output | 1 | high-level enable on half A |
| sg_b | output | 1 | high-level enable on half B |
| sub | output | 1 | substrate sweep pulse |
| pblk | output | 1 | preblank: samples to be ignored |
| pix_valid | output | 1 | real pixel position (not dummy, not blank) |
| ob | output | 1 | optical-black pixel |
| clamp | output | 1 | rear black clamp window |
| eff_win | output | 1 | effective area |
| rec_win | output | 1 | recorded area |

## Verification
Every output is one register stage behind the counter update. After the Nth clock edge following reset release, the outputs describe position N, where position = slot + 4·(pixel + H_TOTAL·line) modulo the frame length. The flop that loads that position drives the output directly. The driver process advances its own position model on each rising edge and queues the full expected output word. The monitor compares that word against the outputs at the next falling edge, so each result is checked in the cycle it becomes due. Configuration changes made mid-frame are mirrored in the model only at the wrap to position 0. The reset-held edges queue the idle word.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
    localparam int SLOTS = 4;   // clocks per pixel, fixed by the in-pixel sequence
    localparam int SG_PIX = 4;  // blanking pixel carrying the sensor gate

    typedef struct packed {
        logic h1, h2, rg, shp, shd;
        logic v1, v2a, v2b, v3, sg_a, sg_b, sub;
        logic pblk, pix_valid, ob, clamp, eff_win, rec_win;
    } tg_out_t;

    localparam tg_out_t OUT_IDLE = '{h2: 1'b1, default: 1'b0};
endpackage

// File: rtl/ccd_tg_counter.sv
module ccd_tg_counter #(
    parameter int H_TOTAL = 1470,
    parameter int V_TOTAL = 1053,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [1:0]    nxt_slot,
    output logic [HW-1:0] nxt_px,
    output logic [VW-1:0] nxt_ln,
    output logic          frame_start
);
    localparam logic [HW-1:0] PX_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] LN_LAST = VW'(V_TOTAL - 1);

    typedef struct packed {
        logic [1:0]    slot;
        logic [HW-1:0] px;
        logic [VW-1:0] ln;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        pos_d.slot = pos_q.slot + 2'd1;
        if (pos_q.slot == 2'd3) begin
            if (pos_q.px == PX_LAST) begin
                pos_d.px = '0;
                pos_d.ln = (pos_q.ln == LN_LAST) ? '0 : pos_q.ln + 1'b1;
            end else begin
                pos_d.px = pos_q.px + 1'b1;
            end
        end
        if (rst) pos_d = '0;
    end

    always_ff @(posedge clk) pos_q <= pos_d;

    assign nxt_slot    = pos_d.slot;
    assign nxt_px      = pos_d.px;
    assign nxt_ln      = pos_d.ln;
    assign frame_start = (pos_d == '0);

    a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
        (pos_q.slot == 2'd3 && pos_q.px == PX_LAST) |=> (pos_q.px == '0 && pos_q.slot == 2'd0));
    a_r1_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (pos_q.slot == 2'd3 && pos_q.px == PX_LAST && pos_q.ln == LN_LAST) |=> (pos_q.ln == '0));
endmodule

// File: rtl/ccd_tg_hdecode.sv
module ccd_tg_hdecode #(
    parameter int H_BLANK = 16,
    parameter int H_DUMMY = 20,
    parameter int H_OBF   = 2,
    parameter int H_EFF   = 1392,
    parameter int H_OBR   = 40,
    parameter int H_REC   = 1360,
    localparam int H_TOTAL = H_BLANK + H_DUMMY + H_OBF + H_EFF + H_OBR,
    localparam int HW = $clog2(H_TOTAL)
) (
    input  logic [1:0]    slot,
    input  logic [HW-1:0] px,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          shp,
    output logic          shd,
    output logic          hblank,
    output logic          hdummy,
    output logic          hob,
    output logic          clamp,
    output logic          heff,
    output logic          hrec
);
    localparam logic [HW-1:0] F0 = HW'(H_BLANK + H_DUMMY);
    localparam logic [HW-1:0] E0 = HW'(H_BLANK + H_DUMMY + H_OBF);
    localparam logic [HW-1:0] R0 = HW'(H_BLANK + H_DUMMY + H_OBF + H_EFF);
    localparam logic [HW-1:0] C0 = HW'(H_BLANK + H_DUMMY + H_OBF + (H_EFF - H_REC) / 2);
    localparam logic [HW-1:0] C1 = HW'(H_BLANK + H_DUMMY + H_OBF + (H_EFF - H_REC) / 2 + H_REC);
    localparam logic [HW-1:0] B0 = HW'(H_BLANK);

    always_comb begin
        hblank = (px < B0);
        hdummy = !hblank && (px < F0);
        heff   = (px >= E0) && (px < R0);
        clamp  = (px >= R0);
        hob    = ((px >= F0) && (px < E0)) || clamp;
        hrec   = (px >= C0) && (px < C1);
        h1     = !hblank && slot[1];
        h2     = hblank || !slot[1];
        rg     = !hblank && (slot == 2'd0);
        shp    = !hblank && (slot == 2'd1);
        shd    = !hblank && (slot == 2'd3);
    end
endmodule

// File: rtl/ccd_tg_vdecode.sv
module ccd_tg_vdecode #(
    parameter int H_TOTAL = 1470,
    parameter int H_BLANK = 16,
    parameter int V_DUMMY = 3,
    parameter int V_OBF   = 8,
    parameter int V_EFF   = 1040,
    parameter int V_OBR   = 2,
    parameter int V_REC   = 1024,
    localparam int V_TOTAL = V_DUMMY + V_OBF + V_EFF + V_OBR,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic [HW-1:0] px,
    input  logic [VW-1:0] ln,
    input  logic          hblank,
    input  logic [VW:0]   shut,
    input  logic          sg_on,
    output logic          v1,
    output logic          v2a,
    output logic          v2b,
    output logic          v3,
    output logic          sg_a,
    output logic          sg_b,
    output logic          sub,
    output logic          vdummy,
    output logic          vob,
    output logic          veff,
    output logic          vrec
);
    import ccd_tg_pkg::*;
    localparam logic [VW-1:0] F0 = VW'(V_DUMMY);
    localparam logic [VW-1:0] E0 = VW'(V_DUMMY + V_OBF);
    localparam logic [VW-1:0] R0 = VW'(V_DUMMY + V_OBF + V_EFF);
    localparam logic [VW-1:0] C0 = VW'(V_DUMMY + V_OBF + (V_EFF - V_REC) / 2);
    localparam logic [VW-1:0] C1 = VW'(V_DUMMY + V_OBF + (V_EFF - V_REC) / 2 + V_REC);
    localparam logic [HW-1:0] P_SG  = HW'(SG_PIX);
    localparam logic [HW-1:0] P_SUB = HW'(H_BLANK - 1);

    logic sg_hit;

    always_comb begin
        sg_hit = hblank && sg_on && (ln == '0) && (px == P_SG);
        v1     = hblank && (px == HW'(0));
        v2a    = (hblank && (px == HW'(1) || px == HW'(3))) || sg_hit;
        v2b    = v2a;
        v3     = hblank && (px == HW'(2));
        sg_a   = sg_hit;
        sg_b   = sg_hit;
        sub    = hblank && (px == P_SUB) && ({1'b0, ln} < shut);
        vdummy = (ln < F0);
        vob    = !vdummy && ((ln < E0) || (ln >= R0));
        veff   = (ln >= E0) && (ln < R0);
        vrec   = (ln >= C0) && (ln < C1);
    end
endmodule

// File: rtl/ccd_tg.sv
module ccd_tg #(
    parameter int H_BLANK = 16,
    parameter int H_DUMMY = 20,
    parameter int H_OBF   = 2,
    parameter int H_EFF   = 1392,
    parameter int H_OBR   = 40,
    parameter int H_REC   = 1360,
    parameter int V_DUMMY = 3,
    parameter int V_OBF   = 8,
    parameter int V_EFF   = 1040,
    parameter int V_OBR   = 2,
    parameter int V_REC   = 1024,
    localparam int H_TOTAL = H_BLANK + H_DUMMY + H_OBF + H_EFF + H_OBR,
    localparam int V_TOTAL = V_DUMMY + V_OBF + V_EFF + V_OBR,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [VW:0] shut_line,
    input  logic        sg_en,
    output logic        h1,
    output logic        h2,
    output logic        rg,
    output logic        shp,
    output logic        shd,
    output logic        v1,
    output logic        v2a,
    output logic        v2b,
    output logic        v3,
    output logic        sg_a,
    output logic        sg_b,
    output logic        sub,
    output logic        pblk,
    output logic        pix_valid,
    output logic        ob,
    output logic        clamp,
    output logic        eff_win,
    output logic        rec_win
);
    import ccd_tg_pkg::*;

    typedef struct packed {
        logic [VW:0] shut;
        logic        sg_on;
        tg_out_t     o;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]    n_slot;
    logic [HW-1:0] n_px;
    logic [VW-1:0] n_ln;
    logic          fs;
    logic hh1, hh2, hrg, hshp, hshd, hblank, hdummy, hob, hclamp, heff, hrec;
    logic vv1, vv2a, vv2b, vv3, vsga, vsgb, vsub, vdummy, vob, veff, vrec;

    ccd_tg_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) cnt_i (
        .clk(clk), .rst(rst), .nxt_slot(n_slot), .nxt_px(n_px),
        .nxt_ln(n_ln), .frame_start(fs)
    );

    ccd_tg_hdecode #(.H_BLANK(H_BLANK), .H_DUMMY(H_DUMMY), .H_OBF(H_OBF),
                     .H_EFF(H_EFF), .H_OBR(H_OBR), .H_REC(H_REC)) hdec_i (
        .slot(n_slot), .px(n_px), .h1(hh1), .h2(hh2), .rg(hrg), .shp(hshp),
        .shd(hshd), .hblank(hblank), .hdummy(hdummy), .hob(hob),
        .clamp(hclamp), .heff(heff), .hrec(hrec)
    );

    ccd_tg_vdecode #(.H_TOTAL(H_TOTAL), .H_BLANK(H_BLANK), .V_DUMMY(V_DUMMY),
                     .V_OBF(V_OBF), .V_EFF(V_EFF), .V_OBR(V_OBR),
                     .V_REC(V_REC)) vdec_i (
        .px(n_px), .ln(n_ln), .hblank(hblank), .shut(st_q.shut),
        .sg_on(st_q.sg_on), .v1(vv1), .v2a(vv2a), .v2b(vv2b), .v3(vv3),
        .sg_a(vsga), .sg_b(vsgb), .sub(vsub), .vdummy(vdummy), .vob(vob),
        .veff(veff), .vrec(vrec)
    );

    always_comb begin
        st_d = st_q;
        if (rst || fs) begin
            st_d.shut  = shut_line;
            st_d.sg_on = sg_en;
        end
        st_d.o.h1  = hh1;
        st_d.o.h2  = hh2;
        st_d.o.rg  = hrg;
        st_d.o.shp = hshp;
        st_d.o.shd = hshd;
        st_d.o.v1  = vv1;
        st_d.o.v2a = vv2a;
        st_d.o.v2b = vv2b;
        st_d.o.v3  = vv3;
        st_d.o.sg_a = vsga;
        st_d.o.sg_b = vsgb;
        st_d.o.sub  = vsub;
        st_d.o.pblk = hblank;
        st_d.o.pix_valid = !hblank && !hdummy && !vdummy;
        st_d.o.ob      = !hblank && !hdummy && !vdummy && (hob || vob);
        st_d.o.clamp   = hclamp;
        st_d.o.eff_win = heff && veff;
        st_d.o.rec_win = hrec && vrec;
        if (rst) st_d.o = OUT_IDLE;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign h1 = st_q.o.h1;
    assign h2 = st_q.o.h2;
    assign rg = st_q.o.rg;
    assign shp = st_q.o.shp;
    assign shd = st_q.o.shd;
    assign v1 = st_q.o.v1;
    assign v2a = st_q.o.v2a;
    assign v2b = st_q.o.v2b;
    assign v3 = st_q.o.v3;
    assign sg_a = st_q.o.sg_a;
    assign sg_b = st_q.o.sg_b;
    assign sub = st_q.o.sub;
    assign pblk = st_q.o.pblk;
    assign pix_valid = st_q.o.pix_valid;
    assign ob = st_q.o.ob;
    assign clamp = st_q.o.clamp;
    assign eff_win = st_q.o.eff_win;
    assign rec_win = st_q.o.rec_win;

    a_r2_h_complement: assert property (@(posedge clk) disable iff (rst) h1 != h2);
    a_r2_rg_h1_deep: assert property (@(posedge clk) disable iff (rst) rg |-> !h1);
    a_r2_shd_in_transfer: assert property (@(posedge clk) disable iff (rst) shd |-> h1);
    a_r2_shp_before_transfer: assert property (@(posedge clk) disable iff (rst) shp |=> h1);
    a_r3_blank_idle: assert property (@(posedge clk) disable iff (rst) pblk |-> (!h1 && !rg && !shp && !shd));
    a_r5_gate_on_v2: assert property (@(posedge clk) disable iff (rst) (sg_a || sg_b) |-> (v2a && v2b && pblk));
    a_r6_sweep_in_blank: assert property (@(posedge clk) disable iff (rst) sub |-> (pblk && !eff_win));
    a_r7_ob_valid: assert property (@(posedge clk) disable iff (rst) ob |-> pix_valid);
    a_r8_rec_in_eff: assert property (@(posedge clk) disable iff (rst) rec_win |-> eff_win);
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst) !fs |=> ($stable(st_q.shut) && $stable(st_q.sg_on)));
endmodule

// File: tb/ccd_tg_tb_top.sv
module ccd_tg_tb_top;
    localparam int HB = 6, HD = 2, HOF = 1, HE = 8, HOR = 2, HR = 4;
    localparam int VD = 1, VOF = 2, VE = 4, VOR = 1, VR = 2;
    localparam int HT = HB + HD + HOF + HE + HOR;
    localparam int VT = VD + VOF + VE + VOR;
    localparam int VW = $clog2(VT);
    localparam int FRAME = 4 * HT * VT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [VW:0] shut_line = '0;
    logic sg_en = 1'b0;
    logic h1, h2, rg, shp, shd, v1, v2a, v2b, v3, sg_a, sg_b, sub;
    logic pblk, pix_valid, ob, clamp, eff_win, rec_win;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [17:0] w;
        bit in_rst;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    ccd_tg #(.H_BLANK(HB), .H_DUMMY(HD), .H_OBF(HOF), .H_EFF(HE), .H_OBR(HOR),
             .H_REC(HR), .V_DUMMY(VD), .V_OBF(VOF), .V_EFF(VE), .V_OBR(VOR),
             .V_REC(VR)) dut_i (
        .clk(clk), .rst(rst), .shut_line(shut_line), .sg_en(sg_en),
        .h1(h1), .h2(h2), .rg(rg), .shp(shp), .shd(shd), .v1(v1), .v2a(v2a),
        .v2b(v2b), .v3(v3), .sg_a(sg_a), .sg_b(sg_b), .sub(sub), .pblk(pblk),
        .pix_valid(pix_valid), .ob(ob), .clamp(clamp), .eff_win(eff_win),
        .rec_win(rec_win)
    );

    // expected output word from position and captured configuration
    function automatic logic [17:0] model(int pos, int sh, bit sg);
        int s = pos % 4;
        int p = (pos / 4) % HT;
        int l = pos / (4 * HT);
        bit hb = p < HB;
        bit hd = !hb && p < HB + HD;
        bit hof = p >= HB + HD && p < HB + HD + HOF;
        bit hor = p >= HB + HD + HOF + HE;
        bit he = p >= HB + HD + HOF && p < HB + HD + HOF + HE;
        bit hr = p >= HB + HD + HOF + (HE - HR) / 2 && p < HB + HD + HOF + (HE - HR) / 2 + HR;
        bit vd = l < VD;
        bit vo = !vd && (l < VD + VOF || l >= VD + VOF + VE);
        bit ve = l >= VD + VOF && l < VD + VOF + VE;
        bit vr = l >= VD + VOF + (VE - VR) / 2 && l < VD + VOF + (VE - VR) / 2 + VR;
        bit gate = hb && sg && l == 0 && p == 4;
        bit val = !hb && !hd && !vd;
        logic [17:0] w;
        w[17] = !hb && s >= 2;
        w[16] = hb || s < 2;
        w[15] = !hb && s == 0;
        w[14] = !hb && s == 1;
        w[13] = !hb && s == 3;
        w[12] = hb && p == 0;
        w[11] = (hb && (p == 1 || p == 3)) || gate;
        w[10] = w[11];
        w[9]  = hb && p == 2;
        w[8]  = gate;
        w[7]  = gate;
        w[6]  = hb && p == HB - 1 && l < sh;
        w[5]  = hb;
        w[4]  = val;
        w[3]  = val && (hof || hor || vo);
        w[2]  = hor;
        w[1]  = he && ve;
        w[0]  = hr && vr;
        return w;
    endfunction

    function automatic string tag_of(int b);
        if (b >= 13) return "R2";
        if (b == 12) return "R1,R4";
        if (b >= 9) return "R4";
        if (b >= 7) return "R5,R11";
        if (b == 6) return "R6,R11";
        if (b == 5) return "R3";
        if (b >= 3) return "R7";
        if (b == 2) return "R9";
        return "R8";
    endfunction

    // driver: mirrors the position and configuration capture after each edge
    initial begin
        int pos = 0;
        int sh = 0;
        bit sg = 1'b0;
        exp_t e;
        forever begin
            @(posedge clk);
            if (rst) begin
                pos = 0;
                sh = int'(shut_line);
                sg = sg_en;
                e.w = 18'h10000;
                e.in_rst = 1'b1;
            end else begin
                pos = (pos + 1) % FRAME;
                if (pos == 0) begin  // R11: capture only at frame start
                    sh = int'(shut_line);
                    sg = sg_en;
                end
                e.w = model(pos, sh, sg);
                e.in_rst = 1'b0;
            end
            sbq.push_back(e);
        end
    end

    // monitor: compares away from the active edge
    initial begin
        exp_t e;
        logic [17:0] act;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                act = {h1, h2, rg, shp, shd, v1, v2a, v2b, v3, sg_a, sg_b, sub,
                       pblk, pix_valid, ob, clamp, eff_win, rec_win};
                total++;
                if (act !== e.w) begin
                    bad++;
                    for (int b = 17; b >= 0; b--)
                        if (act[b] !== e.w[b]) begin
                            $display("FAIL %s bit%0d act=%b exp=%b t=%0t",
                                     e.in_rst ? "R10" : tag_of(b), b, act[b], e.w[b], $time);
                            break;
                        end
                end
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        shut_line = (VW + 1)'(3);
        sg_en = 1'b1;
        run(4);                       // R10: idle words checked during reset
        rst = 1'b0;
        run(FRAME + 40);              // gate and sweep on lines 0..2
        shut_line = '0;               // R11: mid-frame change, waits for wrap
        sg_en = 1'b0;
        run(FRAME);
        shut_line = (VW + 1)'(VT);    // sweep on every line
        sg_en = 1'b1;
        run(2 * FRAME);
        shut_line = (VW + 1)'(1);
        run(300);
        rst = 1'b1;                   // R10: reset in mid-frame
        run(3);
        rst = 1'b0;
        run(FRAME + 20);
        run(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule